// File: doc/BRIEF.md
# Display Transmitter I2C Register Target

This block is the register side of an I2C target that sits in front of a display transmitter. It works one byte at a time. A bit-level bus engine upstream turns bus activity into transaction events (write-start, read-start, finish, nack), write strobes that carry a byte, and read requests. For each read request the block returns one byte. The line-level physical layer is outside the block, and so is the separate responder that serves the display identification data.

The block keeps an 8-bit register pointer. The first byte after a write-start loads the pointer. Each data byte that is read or written after that moves the pointer on by one. The block reports a fixed identity byte and a hot-plug status byte in which a sink is present and no interrupt is pending.

A control register runs a two-step handshake. First the host asks for the pass-through display data channel. Then it confirms the grant, and the block moves into pass-through mode. Pass-through mode appears on an output, so that bus routing elsewhere can follow it.

Top module: `i2cstub_regs`

## Requirements
- R1: Reset clears the pointer to 0x00, pass-through mode and the skip-finish flag, and it drops any pending request. After reset, a byte written with no prior write-start is treated as data, which moves the pointer from 0x00 to 0x01.
- R2: A write-start event arms an address phase. The next written byte is loaded into the pointer without increment and has no effect as register data. For example, an address byte of 0x1A leaves the mode unchanged.
- R3: After each data byte that is written, and after each read request, the pointer increases by one. It wraps from 0xFF to 0x00.
- R4: A read with the pointer at 0x1B returns 0xB0.
- R5: A read with the pointer at 0x3D returns 0x04. Bit 0, the hot-plug interrupt, is never set.
- R6: Writing a data byte to 0x1A with bit 2 (request) and bit 1 (grant) both set enters pass-through mode and sets the skip-finish flag. A later finish event clears the skip-finish flag and leaves the mode unchanged.
- R7: Writing a data byte to 0x1A with bit 2 set records a pending request, and the mode does not change when bit 1 is clear. Reading 0x1A returns 0x06 while a request is pending and 0x00 otherwise.
- R8: Writing a data byte to 0x1A with bit 2 clear drops the pending request and leaves pass-through mode.
- R9: Bits 4, 3 and 0 of a byte written to 0x1A have no effect on the mode, on the pending request or on the read-back value.
- R10: A read at any address other than 0x1A, 0x1B or 0x3D returns 0x00. A write to any other address changes nothing except the pointer.
- R11: Read-start, finish and nack events leave the pointer unchanged, so a read that follows a write continues from the address that write set. Read data is valid in the same cycle as the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_wr_start | input | 1 | Write transaction start event |
| ev_rd_start | input | 1 | Read transaction start event |
| ev_finish | input | 1 | Transaction finish event |
| ev_nack | input | 1 | Not-acknowledge event |
| wr_stb | input | 1 | Written byte strobe |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read byte request |
| rd_data | output | 8 | Read byte, valid while rd_req is high |
| cur_ptr | output | 8 | Current register pointer |
| ddc_mode | output | 1 | Pass-through display data channel mode |
| skip_finish | output | 1 | Set when the next finish event is to be ignored |

## Verification
The hardest states to reach are the interactions between the address phase and the control register. The bench writes 0x1A and 0x06 as address bytes, which must not be taken as control data. It then confirms that a request without a grant reads back 0x06 while the mode stays off. It also writes control bytes that carry only the power, mute and output-mode bits. The bench further drives the pointer to 0xFF to see the wrap, and it issues finish events while the skip flag is set and while it is clear. A pseudo-random phase mixes events, address bytes and data bytes, and the bench compares every cycle against its behavioural model.

// File: rtl/i2cstub_pkg.sv
package i2cstub_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic wr_start;
      logic rd_start;
      logic finish;
      logic nack;
   } i2c_ev_t;
endpackage

// File: rtl/i2cstub_ptr.sv
module i2cstub_ptr #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_wr_start,
   input  logic             wr_stb,
   input  logic [PTR_W-1:0] wr_data,
   input  logic             rd_req,
   output logic [PTR_W-1:0] ptr,
   output logic             addr_phase,
   output logic             data_we
);
   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   assign data_we = wr_stb && !addr_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr        <= '0;
         addr_phase <= 1'b0;
      end else begin
         if (wr_stb) begin
            if (addr_phase) ptr <= wr_data;
            else            ptr <= ptr + ONE;
         end else if (rd_req) begin
            ptr <= ptr + ONE;
         end
         if (ev_wr_start)  addr_phase <= 1'b1;
         else if (wr_stb)  addr_phase <= 1'b0;
      end
   end

   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we || (rd_req && !wr_stb)) |=> ptr == $past(ptr) + ONE);

   assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !rd_req) |=> $stable(ptr));

   assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr_phase) |=> ptr == $past(wr_data));
endmodule

// File: rtl/i2cstub_link.sv
module i2cstub_link #(
   parameter int              DATA_W   = 8,
   parameter logic [7:0]      CTRL_ADR = 8'h1A,
   parameter int              REQ_BIT  = 2,
   parameter int              GNT_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_we,
   input  logic [7:0]        ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ev_finish,
   output logic              req_pend,
   output logic              ddc_on,
   output logic              skip_fin
);
   logic ctrl_we;
   logic req_bit, gnt_bit;

   assign ctrl_we = data_we && (ptr == CTRL_ADR);
   assign req_bit = wr_data[REQ_BIT];
   assign gnt_bit = wr_data[GNT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_pend <= 1'b0;
         ddc_on   <= 1'b0;
         skip_fin <= 1'b0;
      end else begin
         if (ev_finish) skip_fin <= 1'b0;
         if (ctrl_we) begin
            if (req_bit) begin
               req_pend <= 1'b1;
               if (gnt_bit) begin
                  ddc_on   <= 1'b1;
                  skip_fin <= 1'b1;
               end
            end else begin
               req_pend <= 1'b0;
               ddc_on   <= 1'b0;
            end
         end
      end
   end

   assert_grant_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && req_bit && gnt_bit) |=> (ddc_on && skip_fin && req_pend));

   assert_drop_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !req_bit) |=> (!ddc_on && !req_pend));

   assert_mode_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ddc_on |-> req_pend);

   assert_finish_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_finish && !ctrl_we) |=> (!skip_fin && $stable(ddc_on)));
endmodule

// File: rtl/i2cstub_rdmux.sv
module i2cstub_rdmux #(
   parameter int                   DATA_W    = 8,
   parameter int                   NUM_FIXED = 2,
   parameter logic [NUM_FIXED*8-1:0]      FIX_ADR = {8'h3D, 8'h1B},
   parameter logic [NUM_FIXED*DATA_W-1:0] FIX_VAL = {8'h04, 8'hB0},
   parameter logic [7:0]           CTRL_ADR  = 8'h1A,
   parameter int                   REQ_BIT   = 2,
   parameter int                   GNT_BIT   = 1
) (
   input  logic [7:0]        ptr,
   input  logic              req_pend,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [DATA_W-1:0] CTRL_ACK =
      DATA_W'((1 << REQ_BIT) | (1 << GNT_BIT));

   logic [NUM_FIXED-1:0]      hit;
   logic [DATA_W-1:0]         part [NUM_FIXED];

   for (genvar i = 0; i < NUM_FIXED; i++) begin : g_fixed
      assign hit[i]  = (ptr == FIX_ADR[i*8 +: 8]);
      assign part[i] = hit[i] ? FIX_VAL[i*DATA_W +: DATA_W] : '0;
   end

   always_comb begin
      rd_data = '0;
      if (ptr == CTRL_ADR) begin
         if (req_pend) rd_data = CTRL_ACK;
      end else begin
         for (int k = 0; k < NUM_FIXED; k++) rd_data = rd_data | part[k];
      end
   end
endmodule

// File: rtl/i2cstub_regs.sv
module i2cstub_regs #(
   parameter int         DATA_W    = 8,
   parameter logic [7:0] CTRL_ADR  = 8'h1A,
   parameter logic [7:0] ID_ADR    = 8'h1B,
   parameter logic [7:0] ID_VAL    = 8'hB0,
   parameter logic [7:0] STAT_ADR  = 8'h3D,
   parameter logic [7:0] STAT_VAL  = 8'h04,
   parameter int         REQ_BIT   = 2,
   parameter int         GNT_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_wr_start,
   input  logic              ev_rd_start,
   input  logic              ev_finish,
   input  logic              ev_nack,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [7:0]        cur_ptr,
   output logic              ddc_mode,
   output logic              skip_finish
);
   import i2cstub_pkg::*;

   localparam int NUM_FIXED = 2;

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("i2cstub_regs: DATA_W must equal the bus byte width");
   end
   if (REQ_BIT == GNT_BIT || REQ_BIT >= DATA_W || GNT_BIT >= DATA_W) begin : g_bad_bits
      $error("i2cstub_regs: request and grant bits must be distinct and in range");
   end
   if (ID_ADR == CTRL_ADR || STAT_ADR == CTRL_ADR || ID_ADR == STAT_ADR) begin : g_bad_map
      $error("i2cstub_regs: register addresses must be distinct");
   end

   i2c_ev_t ev;
   logic    addr_phase, data_we, req_pend;

   assign ev = '{wr_start: ev_wr_start, rd_start: ev_rd_start,
                 finish: ev_finish, nack: ev_nack};

   i2cstub_ptr #(.PTR_W(8)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ev_wr_start(ev.wr_start),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_req(rd_req),
      .ptr(cur_ptr), .addr_phase(addr_phase), .data_we(data_we)
   );

   i2cstub_link #(.DATA_W(DATA_W), .CTRL_ADR(CTRL_ADR),
                  .REQ_BIT(REQ_BIT), .GNT_BIT(GNT_BIT)) u_link (
      .clk(clk), .rst_n(rst_n), .data_we(data_we), .ptr(cur_ptr),
      .wr_data(wr_data), .ev_finish(ev.finish), .req_pend(req_pend),
      .ddc_on(ddc_mode), .skip_fin(skip_finish)
   );

   i2cstub_rdmux #(.DATA_W(DATA_W), .NUM_FIXED(NUM_FIXED),
                   .FIX_ADR({STAT_ADR, ID_ADR}), .FIX_VAL({STAT_VAL, ID_VAL}),
                   .CTRL_ADR(CTRL_ADR), .REQ_BIT(REQ_BIT), .GNT_BIT(GNT_BIT)) u_rdmux (
      .ptr(cur_ptr), .req_pend(req_pend), .rd_data(rd_data)
   );

   logic unused_ev;
   assign unused_ev = ev.rd_start ^ ev.nack;

   assert_id_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cur_ptr == ID_ADR) |-> rd_data == ID_VAL);

   assert_status_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cur_ptr == STAT_ADR) |-> (rd_data == STAT_VAL && !rd_data[0]));

   assert_other_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cur_ptr != ID_ADR && cur_ptr != STAT_ADR && cur_ptr != CTRL_ADR)
      |-> rd_data == '0);
endmodule

// File: tb/i2cstub_regs_tb.sv
`timescale 1ns/1ps
module i2cstub_regs_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_wr_start = 0, ev_rd_start = 0, ev_finish = 0, ev_nack = 0;
   logic       wr_stb = 0, rd_req = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] rd_data, cur_ptr;
   logic       ddc_mode, skip_finish;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   // reference model state
   int  m_ptr = 0;
   bit  m_addr = 0, m_pend = 0, m_ddc = 0, m_skip = 0;

   always #4 clk = ~clk;

   i2cstub_regs u_dut (
      .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
      .ev_finish(ev_finish), .ev_nack(ev_nack), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_req(rd_req), .rd_data(rd_data), .cur_ptr(cur_ptr), .ddc_mode(ddc_mode),
      .skip_finish(skip_finish)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int mread(input int p);
      case (p)
         8'h1A:   return m_pend ? 8'h06 : 8'h00;
         8'h1B:   return 8'hB0;
         8'h3D:   return 8'h04;
         default: return 8'h00;
      endcase
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
      end
   end

   // one bus cycle; compares read data mid-cycle and state after the edge
   task automatic step(input string req, input bit ws, input bit rs, input bit fn,
                       input bit nk, input bit wst, input logic [7:0] wd, input bit rr);
      @(negedge clk);
      ev_wr_start = ws; ev_rd_start = rs; ev_finish = fn; ev_nack = nk;
      wr_stb = wst; wr_data = wd; rd_req = rr;
      #1;
      if (rr) chk(req, "rd_data", int'(rd_data), mread(m_ptr));
      if (fn) m_skip = 0;
      if (wst) begin
         if (m_addr) m_ptr = int'(wd);
         else begin
            if (m_ptr == 8'h1A) begin
               if (wd[2]) begin
                  m_pend = 1;
                  if (wd[1]) begin m_ddc = 1; m_skip = 1; end
               end else begin
                  m_pend = 0; m_ddc = 0;
               end
            end
            m_ptr = (m_ptr + 1) % 256;
         end
      end else if (rr) m_ptr = (m_ptr + 1) % 256;
      if (ws) m_addr = 1; else if (wst) m_addr = 0;
      @(posedge clk); #1;
      ev_wr_start = 0; ev_rd_start = 0; ev_finish = 0; ev_nack = 0;
      wr_stb = 0; rd_req = 0;
      chk(req, "cur_ptr", int'(cur_ptr), m_ptr);
      chk(req, "ddc_mode", int'(ddc_mode), int'(m_ddc));
      chk(req, "skip_finish", int'(skip_finish), int'(m_skip));
   endtask

   task automatic set_ptr(input string req, input logic [7:0] a);
      step(req, 1, 0, 0, 0, 0, 8'h00, 0);
      step(req, 0, 0, 0, 0, 1, a, 0);
   endtask

   task automatic wr_reg(input string req, input logic [7:0] a, input logic [7:0] d);
      set_ptr(req, a);
      step(req, 0, 0, 0, 0, 1, d, 0);
      step(req, 0, 0, 1, 0, 0, 8'h00, 0);
   endtask

   task automatic rd_reg(input string req, input logic [7:0] a);
      set_ptr(req, a);
      step(req, 0, 1, 0, 0, 0, 8'h00, 0);
      step(req, 0, 0, 0, 0, 0, 8'h00, 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      m_ptr = 0; m_addr = 0; m_pend = 0; m_ddc = 0; m_skip = 0;
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1: reset state
      chk("R1", "cur_ptr", int'(cur_ptr), 0);
      chk("R1", "ddc_mode", int'(ddc_mode), 0);
      chk("R1", "skip_finish", int'(skip_finish), 0);
      // R1: byte without write-start is data; pointer 0 -> 1
      step("R1", 0, 0, 0, 0, 1, 8'h55, 0);

      // R4 identity, then R3 increment and R10 neighbour read
      rd_reg("R4", 8'h1B);
      step("R10", 0, 0, 0, 0, 0, 8'h00, 1);
      // R5 status
      rd_reg("R5", 8'h3D);
      chk("R5", "hotplug bit", int'(rd_data[0]), 0);

      // R2: address bytes equal to control address / grant pattern are not data
      set_ptr("R2", 8'h1A);
      set_ptr("R2", 8'h06);
      rd_reg("R2", 8'h1A);

      // R7: request without grant
      wr_reg("R7", 8'h1A, 8'h04);
      rd_reg("R7", 8'h1A);
      // R6: request and grant; finish clears skip only
      set_ptr("R6", 8'h1A);
      step("R6", 0, 0, 0, 0, 1, 8'h06, 0);
      step("R6", 0, 0, 1, 0, 0, 8'h00, 0);
      // R8: drop with side bits set
      wr_reg("R8", 8'h1A, 8'h19);
      rd_reg("R8", 8'h1A);
      // R9: side bits alongside request and grant
      wr_reg("R9", 8'h1A, 8'h1F);
      rd_reg("R9", 8'h1A);
      wr_reg("R9", 8'h1A, 8'h0D);
      rd_reg("R9", 8'h1A);
      wr_reg("R8", 8'h1A, 8'h00);

      // R10: write to an unrelated register changes nothing but the pointer
      wr_reg("R10", 8'h1A, 8'h06);
      wr_reg("R10", 8'h40, 8'hFF);
      rd_reg("R10", 8'h40);
      rd_reg("R10", 8'h1A);

      // R3: wrap of the pointer on read and on write
      rd_reg("R3", 8'hFF);
      set_ptr("R3", 8'hFF);
      step("R3", 0, 0, 0, 0, 1, 8'h00, 0);

      // R11: events alone keep the pointer; read continues after repeated start
      set_ptr("R11", 8'h1B);
      step("R11", 0, 1, 0, 0, 0, 8'h00, 0);
      step("R11", 0, 0, 0, 1, 0, 8'h00, 0);
      step("R11", 0, 0, 1, 0, 0, 8'h00, 0);
      step("R11", 0, 0, 0, 0, 0, 8'h00, 1);

      // R1: reset while in pass-through mode
      wr_reg("R1", 8'h1A, 8'h06);
      do_reset();
      #1;
      chk("R1", "cur_ptr", int'(cur_ptr), 0);
      chk("R1", "ddc_mode", int'(ddc_mode), 0);
      chk("R1", "skip_finish", int'(skip_finish), 0);
      rd_reg("R1", 8'h1A);

      // mixed traffic against the model
      for (int i = 0; i < 400; i++) begin
         logic [7:0] d;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         d = lfsr[7:0];
         case (lfsr[11:9])
            3'd0: step("R2", 1, 0, 0, 0, 0, 8'h00, 0);
            3'd1: step("R3", 0, 0, 0, 0, 1, lfsr[15] ? 8'h1A : d, 0);
            3'd2: step("R6", 0, 0, 0, 0, 1, {3'b000, d[4:0]}, 0);
            3'd3: step("R11", 0, lfsr[14], lfsr[13], lfsr[12], 0, 8'h00, 0);
            3'd4: step("R7", 0, 0, 0, 0, 0, 8'h00, 1);
            3'd5: set_ptr("R10", lfsr[15] ? 8'h1A : d);
            3'd6: step("R4", 0, 0, 0, 0, 0, 8'h00, 1);
            default: step("R11", 0, 0, 0, 0, 0, 8'h00, 0);
         endcase
      end

      done = 1;
      summary();
   end
endmodule